// File: doc/BRIEF.md
# Host sequencer for a single-wire bus-port serial memory

This block sits on the host side of a 512-byte nonvolatile memory that hangs on an ordinary parallel bus but moves data one bit at a time over a single data wire. Each bus access is a single-bit cycle. The memory understands a command only as a pattern of such cycles. The sequencer takes one byte-level request at a time through a valid/ready handshake. A request is either a read of a number of bytes from an address, or a write of up to eight bytes that stay inside one eight-byte page. The sequencer expands the request into the bit-cycle patterns the memory expects.

Every request starts with the memory's re-synchronisation pattern. A 16-bit address frame follows. A read then returns bytes on a one-cycle-pulsed data stream. A write sends its data bits, then the program-start pattern, and then polls the data wire until the memory reports that programming has finished. The chip-select, output-enable and write-enable strobes are active low. Their widths are counted in system clocks. The data wire is split into an output value, an output enable and an input value, so that a pad cell can join them.

Top module: `bitport_mem_host`

## Requirements
- R1: Every accepted request begins its bus traffic with a read cycle, a write cycle driving 0 and a read cycle, in that order.
- R2: The address frame follows as 16 write cycles sent most significant bit first. Frame bits 15..9 are 0 and frame bits 8..0 carry `req_addr_i`. No read cycle occurs inside the frame.
- R3: A read of `req_len_i` bytes takes 8 read cycles per byte and assembles each byte most significant bit first. Each byte is presented on `rd_data_o` with a one-cycle `rd_valid_o` pulse. The bytes come from consecutive addresses, and address 0x1FF is followed by 0x000.
- R4: A write sends byte k, taken from `req_wdata_i[8k+7:8k]`, to address `req_addr_i + k`. Each byte takes 8 write cycles, most significant bit first, for k = 0 to `req_len_i - 1`.
- R5: After its data, a write issues a read cycle, a write cycle driving 1 and a read cycle. It then issues read cycles until the data wire reads 1, and finishes with `done_o` high and `err_o` low.
- R6: Output enable and write enable are never both low while chip select is low.
- R7: The data wire is driven only while chip select is low and output enable is high, that is, in write cycles.
- R8: A request with a length of 0 is rejected, and so is a write with `req_addr_i[2:0] + req_len_i > 8`. A rejected request raises `done_o` and `err_o` one clock after acceptance and causes no bus cycle.
- R9: If `POLL_MAX` consecutive poll reads all return 0, the write ends with `done_o` and `err_o` high and no further poll is issued.
- R10: Chip select returns high between any two bus cycles, and it rises in the clock after the active strobe is released. Strobe low and chip-select high widths are set by `LOW_W` and `HIGH_W`.
- R11: `req_ready_o` is high only when no request is in progress. `busy_o` is high while a request is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer idle, request accepted when valid |
| req_write_i | input | 1 | 1 = page write, 0 = read |
| req_addr_i | input | ADDR_W | Start byte address |
| req_len_i | input | LEN_W | Byte count |
| req_wdata_i | input | 8*PAGE_BYTES | Write bytes, byte k in bits 8k+7..8k |
| rd_data_o | output | 8 | Read byte |
| rd_valid_o | output | 1 | One-cycle pulse per read byte |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle pulse at request end |
| err_o | output | 1 | With done_o: request rejected or poll timed out |
| mem_ce_no | output | 1 | Memory chip select, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_we_no | output | 1 | Memory write enable, active low |
| mem_io_o | output | 1 | Data wire output value |
| mem_io_oe_o | output | 1 | Data wire output enable |
| mem_io_i | input | 1 | Data wire input value |

## Verification
The strobe and pad properties assume the asynchronous reset is applied before the first request. They also assume that `mem_io_i` carries a defined level whenever an output-enable strobe is low, since a read cycle samples it there.

The bench attaches a behavioural model of the memory. The model always drives a defined 0 or 1 and reacts only to completed strobe pulses. The bench raises requests only while `req_ready_o` is high and holds each one for a single clock. Random writes are restricted to lengths that stay inside their page; the rejected cases are driven only as directed tests.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
  localparam int unsigned FRAME_BITS = 16;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RST, PH_ADDR, PH_RDAT, PH_WDAT, PH_START, PH_POLL
  } phase_e;

  typedef enum logic [2:0] {
    CY_IDLE, CY_SETUP, CY_STROBE, CY_HOLD, CY_GAP
  } cyc_e;
endpackage

// File: rtl/bpm_cycle.sv
// One single-bit bus cycle: setup, strobe low, hold, chip-select-high gap.
module bpm_cycle
  import bpm_pkg::*;
#(
  parameter int unsigned LOW_W  = 2,
  parameter int unsigned HIGH_W = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic ready_o,
  output logic done_o,
  output logic rbit_o,
  output logic ce_no,
  output logic oe_no,
  output logic we_no,
  output logic io_o,
  output logic io_oe_o,
  input  logic io_i
);
  localparam int unsigned MAXW = (LOW_W > HIGH_W) ? LOW_W : HIGH_W;
  localparam int unsigned CW   = $clog2(MAXW + 1);

  cyc_e          st_q;
  logic [CW-1:0] cnt_q;
  logic          wr_q, wbit_q, rbit_q, done_q;
  logic          sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CY_IDLE;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      wbit_q <= 1'b0;
      rbit_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        CY_IDLE: if (start_i) begin
          wr_q   <= wr_i;
          wbit_q <= wbit_i;
          st_q   <= CY_SETUP;
        end
        CY_SETUP: begin
          st_q  <= CY_STROBE;
          cnt_q <= '0;
        end
        CY_STROBE: begin
          if (cnt_q == CW'(LOW_W - 1)) begin
            st_q <= CY_HOLD;
            if (!wr_q) rbit_q <= io_i;  // last edge before OE rises
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        CY_HOLD: begin
          st_q  <= CY_GAP;
          cnt_q <= '0;
        end
        CY_GAP: begin
          if (cnt_q == CW'(HIGH_W - 1)) begin
            st_q   <= CY_IDLE;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= CY_IDLE;
      endcase
    end
  end

  assign sel     = (st_q == CY_SETUP) || (st_q == CY_STROBE) || (st_q == CY_HOLD);
  assign ce_no   = !sel;
  assign oe_no   = !((st_q == CY_STROBE) && !wr_q);
  assign we_no   = !((st_q == CY_STROBE) && wr_q);
  assign io_oe_o = sel && wr_q;
  assign io_o    = wbit_q;
  assign ready_o = (st_q == CY_IDLE);
  assign done_o  = done_q;
  assign rbit_o  = rbit_q;
endmodule

// File: rtl/bpm_timer.sv
// Counts zero-valued status polls; expired_o marks the last allowed one.
module bpm_timer #(
  parameter int unsigned POLL_MAX = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int unsigned TW = $clog2(POLL_MAX + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == TW'(POLL_MAX - 1));
endmodule

// File: rtl/bpm_ctrl.sv
// Request-level sequencer: expands a request into single-bit cycle descriptors.
module bpm_ctrl
  import bpm_pkg::*;
#(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned PAGE_BYTES = 8,
  parameter int unsigned LEN_W      = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic                    req_write_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic [LEN_W-1:0]        req_len_i,
  input  logic [8*PAGE_BYTES-1:0] req_wdata_i,
  output logic [7:0]              rd_data_o,
  output logic                    rd_valid_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    err_o,
  output logic                    cyc_start_o,
  output logic                    cyc_wr_o,
  output logic                    cyc_bit_o,
  input  logic                    cyc_ready_i,
  input  logic                    cyc_done_i,
  input  logic                    cyc_rbit_i,
  output logic                    tmr_clr_o,
  output logic                    tmr_tick_o,
  input  logic                    tmr_exp_i
);
  localparam int unsigned DW   = 8 * PAGE_BYTES;
  localparam int unsigned PW   = $clog2(PAGE_BYTES);
  localparam int unsigned SUMW = ((PW > LEN_W) ? PW : LEN_W) + 1;
  localparam int unsigned FB   = FRAME_BITS;
  localparam int unsigned SW   = $clog2(FB);

  phase_e           ph_q;
  logic [SW-1:0]    step_q;
  logic [2:0]       bit_q;
  logic [LEN_W-1:0] byte_q, len_q;
  logic             wr_q, wait_q;
  logic [FB-1:0]    aw_sr;
  logic [DW-1:0]    wd_sr, wd_ord;
  logic [6:0]       rd_sr;
  logic [SUMW-1:0]  page_end;
  logic             reject, last_byte;

  // reorder so byte 0 leaves first, MSB first
  always_comb begin
    for (int k = 0; k < int'(PAGE_BYTES); k++)
      wd_ord[DW-1-8*k -: 8] = req_wdata_i[8*k +: 8];
  end

  assign page_end  = SUMW'(req_addr_i[PW-1:0]) + SUMW'(req_len_i);
  assign reject    = (req_len_i == '0) ||
                     (req_write_i && (page_end > SUMW'(PAGE_BYTES)));
  assign last_byte = (byte_q == len_q - LEN_W'(1));

  always_comb begin
    cyc_wr_o  = 1'b0;
    cyc_bit_o = 1'b0;
    case (ph_q)
      PH_RST:   cyc_wr_o = (step_q == SW'(1));
      PH_ADDR:  begin cyc_wr_o = 1'b1; cyc_bit_o = aw_sr[FB-1]; end
      PH_WDAT:  begin cyc_wr_o = 1'b1; cyc_bit_o = wd_sr[DW-1]; end
      PH_START: begin cyc_wr_o = (step_q == SW'(1)); cyc_bit_o = 1'b1; end
      default:  ;
    endcase
  end

  assign cyc_start_o = (ph_q != PH_IDLE) && cyc_ready_i && !wait_q;
  assign tmr_clr_o   = (ph_q == PH_START) && cyc_done_i;
  assign tmr_tick_o  = (ph_q == PH_POLL) && cyc_done_i && !cyc_rbit_i;
  assign req_ready_o = (ph_q == PH_IDLE);
  assign busy_o      = (ph_q != PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= PH_IDLE;
      step_q     <= '0;
      bit_q      <= '0;
      byte_q     <= '0;
      len_q      <= '0;
      wr_q       <= 1'b0;
      wait_q     <= 1'b0;
      aw_sr      <= '0;
      wd_sr      <= '0;
      rd_sr      <= '0;
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      rd_valid_o <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      if (cyc_start_o) wait_q <= 1'b1;
      if (ph_q == PH_IDLE) begin
        if (req_valid_i) begin
          if (reject) begin
            done_o <= 1'b1;
            err_o  <= 1'b1;
          end else begin
            ph_q   <= PH_RST;
            step_q <= '0;
            bit_q  <= '0;
            byte_q <= '0;
            len_q  <= req_len_i;
            wr_q   <= req_write_i;
            aw_sr  <= FB'(req_addr_i);
            wd_sr  <= wd_ord;
          end
        end
      end else if (cyc_done_i) begin
        wait_q <= 1'b0;
        case (ph_q)
          PH_RST: begin
            if (step_q == SW'(2)) begin
              ph_q   <= PH_ADDR;
              step_q <= '0;
            end else step_q <= step_q + 1'b1;
          end
          PH_ADDR: begin
            aw_sr <= aw_sr << 1;
            if (step_q == SW'(FB - 1)) begin
              ph_q   <= wr_q ? PH_WDAT : PH_RDAT;
              step_q <= '0;
            end else step_q <= step_q + 1'b1;
          end
          PH_RDAT: begin
            rd_sr <= {rd_sr[5:0], cyc_rbit_i};
            bit_q <= bit_q + 1'b1;
            if (bit_q == 3'd7) begin
              rd_data_o  <= {rd_sr, cyc_rbit_i};
              rd_valid_o <= 1'b1;
              byte_q     <= byte_q + 1'b1;
              if (last_byte) begin
                ph_q   <= PH_IDLE;
                done_o <= 1'b1;
              end
            end
          end
          PH_WDAT: begin
            wd_sr <= wd_sr << 1;
            bit_q <= bit_q + 1'b1;
            if (bit_q == 3'd7) begin
              byte_q <= byte_q + 1'b1;
              if (last_byte) begin
                ph_q   <= PH_START;
                step_q <= '0;
              end
            end
          end
          PH_START: begin
            if (step_q == SW'(2)) ph_q <= PH_POLL;
            else step_q <= step_q + 1'b1;
          end
          PH_POLL: begin
            if (cyc_rbit_i) begin
              ph_q   <= PH_IDLE;
              done_o <= 1'b1;
            end else if (tmr_exp_i) begin
              ph_q   <= PH_IDLE;
              done_o <= 1'b1;
              err_o  <= 1'b1;
            end
          end
          default: ph_q <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/bitport_mem_host.sv
module bitport_mem_host
  import bpm_pkg::*;
#(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned PAGE_BYTES = 8,
  parameter int unsigned LEN_W      = 4,
  parameter int unsigned LOW_W      = 2,
  parameter int unsigned HIGH_W     = 1,
  parameter int unsigned POLL_MAX   = 4096
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic                    req_write_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic [LEN_W-1:0]        req_len_i,
  input  logic [8*PAGE_BYTES-1:0] req_wdata_i,
  output logic [7:0]              rd_data_o,
  output logic                    rd_valid_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    err_o,
  output logic                    mem_ce_no,
  output logic                    mem_oe_no,
  output logic                    mem_we_no,
  output logic                    mem_io_o,
  output logic                    mem_io_oe_o,
  input  logic                    mem_io_i
);
  logic cyc_start, cyc_wr, cyc_bit, cyc_ready, cyc_done, cyc_rbit;
  logic tmr_clr, tmr_tick, tmr_exp;

  bpm_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_write_i, .req_addr_i,
    .req_len_i, .req_wdata_i, .rd_data_o, .rd_valid_o, .busy_o, .done_o, .err_o,
    .cyc_start_o(cyc_start), .cyc_wr_o(cyc_wr), .cyc_bit_o(cyc_bit),
    .cyc_ready_i(cyc_ready), .cyc_done_i(cyc_done), .cyc_rbit_i(cyc_rbit),
    .tmr_clr_o(tmr_clr), .tmr_tick_o(tmr_tick), .tmr_exp_i(tmr_exp)
  );

  bpm_cycle #(.LOW_W(LOW_W), .HIGH_W(HIGH_W)) u_cycle (
    .clk_i, .rst_ni, .start_i(cyc_start), .wr_i(cyc_wr), .wbit_i(cyc_bit),
    .ready_o(cyc_ready), .done_o(cyc_done), .rbit_o(cyc_rbit),
    .ce_no(mem_ce_no), .oe_no(mem_oe_no), .we_no(mem_we_no),
    .io_o(mem_io_o), .io_oe_o(mem_io_oe_o), .io_i(mem_io_i)
  );

  bpm_timer #(.POLL_MAX(POLL_MAX)) u_timer (
    .clk_i, .rst_ni, .clr_i(tmr_clr), .tick_i(tmr_tick), .expired_o(tmr_exp)
  );
endmodule

// File: rtl/bpm_host_chk.sv
module bpm_host_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ce_ni,
  input logic oe_ni,
  input logic we_ni,
  input logic io_oe_i,
  input logic ready_i,
  input logic busy_i,
  input logic done_i,
  input logic err_i
);
  AST_NO_STROBE_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ce_ni && !oe_ni && !we_ni)); // R6

  AST_DRIVE_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_oe_i |-> (!ce_ni && oe_ni)); // R7

  AST_CE_RISES_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(we_ni) || $rose(oe_ni)) |=> $rose(ce_ni)); // R10

  AST_STROBE_UNDER_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_ni || !we_ni) |-> !ce_ni); // R10

  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> done_i); // R8

  AST_READY_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_i && busy_i)); // R11
endmodule

bind bitport_mem_host bpm_host_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(mem_ce_no), .oe_ni(mem_oe_no),
  .we_ni(mem_we_no), .io_oe_i(mem_io_oe_o), .ready_i(req_ready_o),
  .busy_i(busy_o), .done_i(done_o), .err_i(err_o)
);

// File: tb/bitport_mem_host_test.sv
`timescale 1ns/1ps
module bitport_mem_host_test;
  localparam int POLL_MAX = 32;
  localparam int WDOG     = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [8:0]  req_addr = '0;
  logic [3:0]  req_len = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, rd_valid, busy, done, err;
  logic [7:0]  rd_data;
  logic        ce_n, oe_n, we_n, io_o, io_oe, io_i;

  bitport_mem_host #(.LOW_W(2), .HIGH_W(1), .POLL_MAX(POLL_MAX)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_len_i(req_len),
    .req_wdata_i(req_wdata), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .busy_o(busy), .done_o(done), .err_o(err), .mem_ce_no(ce_n),
    .mem_oe_no(oe_n), .mem_we_no(we_n), .mem_io_o(io_o), .mem_io_oe_o(io_oe),
    .mem_io_i(io_i)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  localparam int M_IDLE = 0, M_ADDR = 1, M_READ = 2, M_LOAD = 3,
                 M_LEND = 4, M_ARMED = 5, M_PROG = 6, M_AD = 7;
  logic [7:0] mem [512];
  logic [7:0] ref_mem [512];
  logic [7:0] pbuf [8];
  logic [7:0] pmask;
  int   m_st = M_IDLE, acnt, left, busy_cfg = 0;
  bit   stuck = 0;
  logic [15:0] areg;
  logic [8:0]  rptr;
  logic [2:0]  rbit, lptr, lbit;
  int   ev1 = 3, ev2 = 3;
  int   m_events = 0, m_resets = 0, m_prog_reads = 0, m_addr_bad = 0;
  int   ce_rises = 0, clash = 0, drive_bad = 0;
  logic prev_oe = 1'b1, prev_we = 1'b1, prev_ce = 1'b1;
  logic m_out;

  always_comb begin
    m_out = 1'b1;
    if (m_st == M_READ || m_st == M_AD) m_out = mem[rptr][3'd7 - rbit];
    else if (m_st == M_PROG) m_out = !stuck && (left == 0);
  end
  assign io_i = m_out;

  task automatic m_event(input bit is_w, input bit b);
    int code;
    code = is_w ? (b ? 2 : 1) : 0;
    m_events++;
    if (!is_w && ev1 == 1 && ev2 == 0 && m_st != M_PROG) begin
      m_resets++;
      m_st = M_ADDR; acnt = 0; pmask = '0;
    end else begin
      case (m_st)
        M_ADDR: if (is_w) begin
          areg = {areg[14:0], b};
          acnt++;
          if (acnt == 16) begin
            if (areg[15:9] != 7'd0) m_addr_bad++;
            rptr = areg[8:0]; rbit = 0; lptr = areg[2:0]; lbit = 0;
            m_st = M_AD;
          end
        end else m_st = M_IDLE;
        M_AD, M_READ, M_LOAD: begin
          if (!is_w && m_st != M_LOAD) begin
            m_st = M_READ;
            if (rbit == 3'd7) rptr = rptr + 9'd1;
            rbit = rbit + 3'd1;
          end else if (is_w && m_st != M_READ) begin
            m_st = M_LOAD;
            pbuf[lptr][3'd7 - lbit] = b;
            if (lbit == 3'd7) begin pmask[lptr] = 1'b1; lptr = lptr + 3'd1; end
            lbit = lbit + 3'd1;
          end else if (!is_w && m_st == M_LOAD) begin
            m_st = (lbit == 3'd0) ? M_LEND : M_IDLE;
          end
        end
        M_LEND:  m_st = (code == 2) ? M_ARMED : M_IDLE;
        M_ARMED: if (!is_w) begin m_st = M_PROG; left = busy_cfg; end else m_st = M_IDLE;
        M_PROG: if (!is_w) begin
          m_prog_reads++;
          if (!stuck) begin
            if (left == 0) begin
              for (int k = 0; k < 8; k++)
                if (pmask[k]) mem[{areg[8:3], 3'(k)}] = pbuf[k];
              m_st = M_IDLE;
            end else left--;
          end
        end
        default: ;
      endcase
    end
    ev2 = ev1; ev1 = code;
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      if (!prev_oe && oe_n) m_event(1'b0, 1'b0);
      else if (!prev_we && we_n) m_event(1'b1, io_o);
      if (!prev_ce && ce_n) ce_rises++;
      if (!ce_n && !oe_n && !we_n) clash++;
      if (io_oe && (ce_n || !oe_n)) drive_bad++;
    end
    prev_oe = oe_n; prev_we = we_n; prev_ce = ce_n;
  end

  // ---------------- read stream capture ----------------
  logic [7:0] rd_buf [16];
  int rd_n = 0;
  always @(negedge clk) begin
    if (rd_valid) begin
      if (rd_n < 16) rd_buf[rd_n] = rd_data;
      rd_n++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- request driver ----------------
  int  o_ev, o_rst, o_ce, o_prog;
  bit  o_err, o_sawbusy, o_rdybad;

  task automatic run_req(input bit w, input int addr, input int len, input logic [63:0] data);
    int e0, r0, c0, p0, n;
    e0 = m_events; r0 = m_resets; c0 = ce_rises; p0 = m_prog_reads;
    rd_n = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_write = w; req_addr = 9'(addr); req_len = 4'(len); req_wdata = data;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    o_sawbusy = 0; o_rdybad = 0; n = 0;
    while (!done && n < 20000) begin
      if (busy) o_sawbusy = 1;
      if (busy && req_ready) o_rdybad = 1;
      @(negedge clk); n++;
    end
    chk(n < 20000, "R11 request finished", n, 20000);
    o_err = err;
    @(negedge clk);
    o_ev = m_events - e0; o_rst = m_resets - r0; o_ce = ce_rises - c0;
    o_prog = m_prog_reads - p0;
  endtask

  task automatic do_read(input int addr, input int len);
    run_req(1'b0, addr, len, '0);
    chk(!o_err, "R3 read err", int'(o_err), 0);
    chk(o_rst == 1, "R1 reset pattern seen", o_rst, 1);
    chk(o_ev == 19 + 8 * len, "R3 read bus cycles", o_ev, 19 + 8 * len);
    chk(o_ce == o_ev, "R10 ce high between cycles", o_ce, o_ev);
    chk(rd_n == len, "R3 byte count", rd_n, len);
    chk(o_sawbusy && !o_rdybad, "R11 busy/ready", int'(o_rdybad), 0);
    for (int k = 0; k < len && k < 16; k++)
      chk(rd_buf[k] == ref_mem[(addr + k) % 512], "R3 read data",
          int'(rd_buf[k]), int'(ref_mem[(addr + k) % 512]));
  endtask

  task automatic do_write(input int addr, input int len, input logic [63:0] data, input int b);
    busy_cfg = b;
    run_req(1'b1, addr, len, data);
    chk(!o_err, "R5 write err", int'(o_err), 0);
    chk(o_rst == 1, "R1 reset pattern seen", o_rst, 1);
    chk(o_ev == 23 + 8 * len + b, "R5 write bus cycles", o_ev, 23 + 8 * len + b);
    chk(o_prog == b + 1, "R5 poll reads", o_prog, b + 1);
    chk(o_ce == o_ev, "R10 ce high between cycles", o_ce, o_ev);
    for (int k = 0; k < len; k++) ref_mem[(addr + k) % 512] = data[8*k +: 8];
    do_read(addr, len); // R4 readback
  endtask

  task automatic do_reject(input bit w, input int addr, input int len);
    run_req(w, addr, len, 64'h0123_4567_89ab_cdef);
    chk(o_err, "R8 reject err", int'(o_err), 1);
    chk(o_ev == 0, "R8 no bus cycles", o_ev, 0);
    chk(!o_sawbusy, "R8 never busy", int'(o_sawbusy), 0);
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'd4711);
    for (int i = 0; i < 512; i++) begin
      mem[i] = 8'(i * 37 + 5);
      ref_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk(req_ready && !busy && !done && !err, "R11 reset idle", int'(busy), 0);
    chk(ce_n && oe_n && we_n && !io_oe, "R7 reset bus released", int'(io_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);

    do_read(0, 4);
    do_read(9'h1FC, 8);                      // wraps to 0x000
    do_read(9'h1FF, 1);
    do_write(9'h010, 8, 64'hF00D_CAFE_1234_A5C3, 3);
    do_write(9'h1FD, 3, 64'h0000_0000_0077_8899, 0);  // ends exactly at page end
    do_write(9'h021, 1, 64'h0000_0000_0000_0080, 5);
    do_reject(1'b1, 5, 4);                   // 5+4 > 8
    do_reject(1'b1, 0, 9);
    do_reject(1'b0, 3, 0);
    do_reject(1'b1, 7, 0);

    // poll timeout
    stuck = 1;
    run_req(1'b1, 9'h040, 2, 64'h0000_0000_0000_BEEF);
    chk(o_err, "R9 timeout err", int'(o_err), 1);
    chk(o_prog == POLL_MAX, "R9 poll count", o_prog, POLL_MAX);
    chk(o_ev == 23 + 16 + POLL_MAX - 1, "R9 bus cycles", o_ev, 23 + 16 + POLL_MAX - 1);
    stuck = 0; m_st = M_IDLE;
    do_read(9'h040, 2);                      // unchanged contents

    for (int t = 0; t < 40; t++) begin
      int a, l;
      a = int'($urandom % 512);
      if ($urandom % 2 == 0) begin
        l = 1 + int'($urandom % 15);
        do_read(a, l);
      end else begin
        l = 1 + int'($urandom % (8 - (a % 8)));
        do_write(a, l, {$urandom, $urandom}, int'($urandom % 11));
      end
    end

    chk(clash == 0, "R6 strobe clash", clash, 0);
    chk(drive_bad == 0, "R7 drive outside write", drive_bad, 0);
    chk(m_addr_bad == 0, "R2 address frame top bits", m_addr_bad, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule